// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Receiver

This block is the host side of a one-bit read over a shared, open-drain style debug line. A start strobe begins a bit time. The block pulls the line low for a short fixed window, which gives the target a falling edge it can recognise. It then lets go of the line so that the target can hold it low for a zero, or leave it high and add its speed-up pulse for a one. At a fixed cycle offset from the start of the bit time, the block samples the line and reports the level as the received bit.

The line appears at the ports as a tri-state model. `pin_oe_o` enables the host driver, `pin_o` is the value driven (always low), and `pin_i` is the level seen on the line. The line input passes through a synchronizer chain, and the capture point is moved later by the depth of that chain, so the reported bit reflects the line level at the nominal sample cycle. The result comes out as a one-cycle valid pulse with no back-pressure. The consumer must take `rx_bit_o` while `rx_valid_o` is high, although the bit also stays stable until the next capture. Strobes that arrive while a bit time is still running are dropped, so bit starts are always at least one bit period apart.

Bit cycle k is the k-th clock cycle after the clock edge that accepts a start strobe, counting from k = 0.

Top module: `sw_bit_reader`

## Requirements
- R1: After reset and while idle, `pin_oe_o` is 0, `rx_valid_o` is 0 and `rx_bit_o` is 0.
- R2: An accepted start strobe makes `pin_oe_o` equal to 1 for exactly LOW_CYC (default 3) consecutive bit cycles, 0 to LOW_CYC-1. `pin_o` is 0 whenever `pin_oe_o` is 1.
- R3: The host driver is off (`pin_oe_o` = 0) from bit cycle LOW_CYC through the end of the bit period. This means it is released well before bit cycle 7, where the target may drive its speed-up pulse.
- R4: `rx_bit_o` takes the level of `pin_i` during bit cycle SAMPLE_CYC (default 10), with 1 for high and 0 for low. The levels in all other bit cycles have no effect on it.
- R5: `rx_valid_o` is 1 for exactly one cycle, bit cycle SAMPLE_CYC+SYNC_STAGES+1 (default 13), and 0 in every other cycle. `rx_bit_o` holds its value until the next capture.
- R6: A start strobe during bit cycles 0 to PERIOD_CYC-2 of a running bit time is ignored. The drive window and the capture timing of the running bit are unchanged.
- R7: A start strobe while idle, or during the last bit cycle PERIOD_CYC-1 (default 15), is accepted. Back-to-back bits therefore start exactly PERIOD_CYC (default 16) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a bit time |
| pin_oe_o | output | 1 | Host line driver enable |
| pin_o | output | 1 | Value driven on the line when enabled (always 0) |
| pin_i | input | 1 | Level observed on the line |
| rx_bit_o | output | 1 | Last received bit |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_bit_o` is updated |

## Verification
The bench builds the block with its default parameters: LOW_CYC of 3, SAMPLE_CYC of 10, PERIOD_CYC of 16 and two synchronizer stages. With these values the whole bit period fits in a sixteen-step loop, so every bit cycle is checked on its own. The line is driven with a random level in each cycle, and in directed cases only the level at cycle 10 differs from its neighbours, so a capture that is off by one cycle is exposed. Start strobes are scattered at random across cycles 0 to 14, and others are placed in cycle 15 to chain bits back to back.

// File: rtl/swbr_pkg.sv
package swbr_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BIT  = 1'b1
  } phase_e;
endpackage

// File: rtl/swbr_sync.sv
module swbr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (!rst_ni) chain_q[0] <= 1'b1;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (!rst_ni) chain_q[s] <= 1'b1;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swbr_timer.sv
module swbr_timer
  import swbr_pkg::*;
#(
  parameter int PERIOD_CYC = 16,
  parameter int LOW_CYC    = 3,
  parameter int CW         = $clog2(PERIOD_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output logic          oe_o
);
  localparam logic [CW-1:0] LastCnt = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] RelCnt  = CW'(LOW_CYC - 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          oe_q;
  logic          accept;

  // A strobe is taken when idle or in the final cycle of a bit period.
  assign accept = start_i && ((ph_q == PH_IDLE) || (cnt_q == LastCnt));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (accept) begin
      ph_q  <= PH_BIT;
      cnt_q <= '0;
    end else if (ph_q == PH_BIT) begin
      if (cnt_q == LastCnt) begin
        ph_q  <= PH_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                                 oe_q <= 1'b0;
    else if (accept)                             oe_q <= 1'b1;
    else if (ph_q == PH_BIT && cnt_q == RelCnt)  oe_q <= 1'b0;
  end

  assign busy_o = (ph_q == PH_BIT);
  assign cnt_o  = cnt_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/swbr_sampler.sv
module swbr_sampler #(
  parameter int CW      = 4,
  parameter int CAP_CYC = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          line_i,
  output logic          bit_o,
  output logic          valid_o
);
  localparam logic [CW-1:0] CapCnt = CW'(CAP_CYC);

  logic bit_q, valid_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (busy_i && cnt_i == CapCnt) begin
      bit_q   <= line_i;
      valid_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sw_bit_reader.sv
module sw_bit_reader #(
  parameter int LOW_CYC     = 3,
  parameter int SAMPLE_CYC  = 10,
  parameter int PERIOD_CYC  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pin_oe_o,
  output logic pin_o,
  input  logic pin_i,
  output logic rx_bit_o,
  output logic rx_valid_o
);
  localparam int CW      = $clog2(PERIOD_CYC);
  localparam int CAP_CYC = SAMPLE_CYC + SYNC_STAGES;

  logic          busy;
  logic [CW-1:0] cnt;
  logic          line_s;

  swbr_timer #(
    .PERIOD_CYC(PERIOD_CYC),
    .LOW_CYC   (LOW_CYC),
    .CW        (CW)
  ) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy),
    .cnt_o  (cnt),
    .oe_o   (pin_oe_o)
  );

  swbr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (line_s)
  );

  swbr_sampler #(.CW(CW), .CAP_CYC(CAP_CYC)) sampler_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy),
    .cnt_i  (cnt),
    .line_i (line_s),
    .bit_o  (rx_bit_o),
    .valid_o(rx_valid_o)
  );

  assign pin_o = 1'b0;
endmodule

// File: rtl/swbr_checker.sv
module swbr_checker #(
  parameter int LOW_CYC     = 3,
  parameter int SAMPLE_CYC  = 10,
  parameter int PERIOD_CYC  = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_oe_o,
  input logic pin_o,
  input logic rx_valid_o
);
  localparam int GW = $clog2(PERIOD_CYC) + 2;

  logic [GW-1:0] run_q;
  logic [GW-1:0] gap_q;

  // Consecutive driven cycles so far.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)       run_q <= '0;
    else if (pin_oe_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  // Cycles since the last rise of the drive enable, saturating.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                                    gap_q <= GW'(PERIOD_CYC);
    else if (pin_oe_o && run_q == '0)               gap_q <= GW'(1);
    else if (gap_q < GW'(PERIOD_CYC))               gap_q <= gap_q + 1'b1;
  end

  a_r2_drive_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> !pin_o);

  a_r2_low_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_oe_o) |-> run_q == GW'(LOW_CYC));

  a_r3_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> run_q < GW'(LOW_CYC));

  a_r5_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r5_valid_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> gap_q == GW'(SAMPLE_CYC + SYNC_STAGES + 1));

  a_r7_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_oe_o) |-> gap_q >= GW'(PERIOD_CYC));
endmodule

bind sw_bit_reader swbr_checker #(
  .LOW_CYC    (LOW_CYC),
  .SAMPLE_CYC (SAMPLE_CYC),
  .PERIOD_CYC (PERIOD_CYC),
  .SYNC_STAGES(SYNC_STAGES)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pin_oe_o  (pin_oe_o),
  .pin_o     (pin_o),
  .rx_valid_o(rx_valid_o)
);

// File: tb/sw_bit_reader_tb_top.sv
module sw_bit_reader_tb_top;
  localparam int LOW  = 3;
  localparam int SAMP = 10;
  localparam int PER  = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic line = 1'b1;
  logic pin_oe, pin_drv, pin_in, rx_bit, rx_valid;
  int   checks = 0;
  int   fails = 0;
  logic last_bit = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  assign pin_in = pin_oe ? pin_drv : line;

  sw_bit_reader #(
    .LOW_CYC(LOW), .SAMPLE_CYC(SAMP), .PERIOD_CYC(PER), .SYNC_STAGES(SYNC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pin_oe_o(pin_oe), .pin_o(pin_drv), .pin_i(pin_in),
    .rx_bit_o(rx_bit), .rx_valid_o(rx_valid)
  );

  function automatic logic exp_oe(int k);
    return k < LOW;
  endfunction

  function automatic logic exp_valid(int k);
    return k == SAMP + SYNC + 1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Runs one bit period; called at the negedge of bit cycle 0.
  task automatic bit_body(logic [PER-1:0] pat, bit noise, bit chain);
    for (int k = 0; k < PER; k++) begin
      if (k == PER - 1) start = chain;
      else              start = noise && ($urandom_range(0, 3) == 0);
      line = pat[k];
      check(exp_oe(k) ? "R2 drive window" : "R3 released", pin_oe, exp_oe(k));
      if (pin_oe) check("R2 drive value", pin_drv, 1'b0);
      check(noise ? "R6 valid timing under strobes" : "R5 valid slot",
            rx_valid, exp_valid(k));
      if (exp_valid(k)) begin
        check("R4 sampled bit", rx_bit, pat[SAMP]);
        last_bit = pat[SAMP];
      end else if (k < SAMP + SYNC + 1) begin
        check("R5 bit held", rx_bit, last_bit);
      end
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic kick();
    start = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle_check(int n);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      check("R7 idle no drive", pin_oe, 1'b0);
      check("R5 idle no valid", rx_valid, 1'b0);
      check("R5 bit held idle", rx_bit, last_bit);
      @(posedge clk); @(negedge clk);
    end
  endtask

  function automatic logic [PER-1:0] zero_pat();
    logic [PER-1:0] p = '1;
    for (int k = 0; k < 13; k++) p[k] = 1'b0;
    return p;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 oe after reset", pin_oe, 1'b0);
    check("R1 valid after reset", rx_valid, 1'b0);
    check("R1 bit after reset", rx_bit, 1'b0);
    idle_check(2);

    // Directed: logic one, logic zero, isolated level at the sample cycle.
    kick(); bit_body('1, 1'b0, 1'b0); idle_check(3);
    kick(); bit_body(zero_pat(), 1'b0, 1'b0); idle_check(3);
    kick(); bit_body(PER'(1) << SAMP, 1'b0, 1'b0); idle_check(2);
    kick(); bit_body(~(PER'(1) << SAMP), 1'b0, 1'b0); idle_check(2);

    // R7 back-to-back chain of bits with strobe in the last cycle.
    kick();
    bit_body(PER'($urandom), 1'b0, 1'b1);
    bit_body(zero_pat(), 1'b0, 1'b1);
    bit_body('1, 1'b0, 1'b0);
    idle_check(2);

    // Random patterns with spurious strobes (R6) and random chaining.
    for (int n = 0; n < 120; n++) begin
      kick();
      bit_body(PER'($urandom), 1'b1, 1'b0);
      if ($urandom_range(0, 1) == 1) idle_check($urandom_range(1, 4));
    end
    for (int n = 0; n < 40; n++) begin
      kick();
      bit_body(PER'($urandom), 1'b1, 1'b1);
      bit_body(PER'($urandom), 1'b1, 1'b0);
      idle_check(1);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule